// File: doc/BRIEF.md
# Bus-Attached Memory Subsystem with Programming Mux

This block is the memory side of a small bus-based teaching computer. A 16-word by 4-bit RAM sits behind an address register and a data register. One general-purpose register and an external bus agent share a 4-bit data bus with the RAM read port. The RAM address and the RAM write data each pass through a 2-to-1 selector. In normal operation the selectors take the address register and the data register. In hand-programming mode they take the switch inputs instead, so an operator can fill memory word by word before any program runs.

Every register captures from the shared bus on the rising clock edge, and only while its own load strobe is high. The RAM stores the selected data word at the selected address on the clock edge when its load strobe is high. When its read strobe is high it places the addressed word on the bus within the same cycle. Moving a word from the general register into memory takes three steps: the register drives the bus while the data register loads, then the address is set up, then the RAM load stores the data register's contents. Moving a word out of memory holds the RAM read strobe and the register load together for one clock edge.

Top module: `mem_subsys`

## Requirements
- R1: With `sw_addr_sel` = 1 the RAM address is `sw_addr`; with `sw_addr_sel` = 0 it is the address register output `mar_q`.
- R2: With `sw_data_sel` = 1 the RAM write data is `sw_data`; with `sw_data_sel` = 0 it is the data register output `mdr_q`.
- R3: When `ram_ld` is high at a rising clock edge, the RAM stores the selected write data at the selected address, and a later read of that address returns it.
- R4: While `ram_rd` is high and no other driver is enabled, `bus_out` equals the RAM word at the selected address in the same cycle, with no clock edge needed.
- R5: While `gr_oe` is high and no other driver is enabled, `bus_out` equals `gr_q`. While `ext_oe` is high and no other driver is enabled, `bus_out` equals `ext_data`.
- R6: While none of `ram_rd`, `gr_oe` or `ext_oe` is high, `bus_out` is zero. At most one of the three may be high in any cycle.
- R7: At a rising edge with its load strobe high (`mar_ld`, `mdr_ld` or `gr_ld`), each register takes the value `bus_out` had just before that edge.
- R8: At a rising edge with its load strobe low, a register keeps its value.
- R9: While `rst_n` is low, and for the two rising edges after it goes high, `mar_q`, `mdr_q` and `gr_q` read zero. RAM contents are not cleared.
- R10: A clock edge with `ram_ld` low leaves every RAM word unchanged, whatever the selectors and switches carry.
- R11: Register-to-RAM transfer works: with `sw_data_sel` = 0, one edge with `gr_oe` and `mdr_ld` high, followed by one edge with `ram_ld` high, stores `gr_q` at the selected address.
- R12: RAM-to-register transfer works: one edge with `ram_rd` and `gr_ld` both high leaves the addressed RAM word in `gr_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sw_addr_sel | input | 1 | RAM address select: 1 = switches, 0 = address register |
| sw_data_sel | input | 1 | RAM write data select: 1 = switches, 0 = data register |
| sw_addr | input | 4 | Switch address value |
| sw_data | input | 4 | Switch data value |
| ram_ld | input | 1 | RAM store strobe, sampled on the clock edge |
| ram_rd | input | 1 | RAM drives the addressed word onto the bus |
| mar_ld | input | 1 | Address register loads from the bus |
| mdr_ld | input | 1 | Data register loads from the bus |
| gr_ld | input | 1 | General register loads from the bus |
| gr_oe | input | 1 | General register drives the bus |
| ext_oe | input | 1 | External agent drives the bus |
| ext_data | input | 4 | External agent's bus value |
| bus_out | output | 4 | Shared data bus value |
| mar_q | output | 4 | Address register contents |
| mdr_q | output | 4 | Data register contents |
| gr_q | output | 4 | General register contents |

## Verification
Bus values are combinational. They are due in the same cycle as the strobes and switch values, so the bench checks `bus_out` one nanosecond after it drives inputs at the falling edge. Register contents and RAM stores take effect at the next rising edge. The bench therefore updates its model at that edge and compares `mar_q`, `mdr_q` and `gr_q` at the following falling edge. A stored RAM word is checked on a later cycle, when a read strobe brings it onto the bus. Reset release passes through two synchroniser stages, so the bench waits for them to clear before it applies any strobe.

// File: rtl/mem_pkg.sv
package mem_pkg;
  // Bus driver slots in the shared bus merge
  typedef enum int {
    DRV_RAM = 0,
    DRV_GR  = 1,
    DRV_EXT = 2
  } bus_drv_e;
  localparam int N_BUS_DRV = 3;
  localparam int RST_STAGES = 2;
endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/sel_mux2.sv
module sel_mux2 #(
  parameter int W = 4
) (
  input  logic         sel,
  input  logic [W-1:0] in0,
  input  logic [W-1:0] in1,
  output logic [W-1:0] y
);
  always_comb begin
    y = sel ? in1 : in0;
  end
endmodule

// File: rtl/load_reg.sv
module load_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r;
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q_r;
    if (ld) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_nxt;
  end

  assign q = q_r;
endmodule

// File: rtl/ram_core.sv
module ram_core #(
  parameter int AW = 4,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Contents are deliberately not reset
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  always_comb begin
    rdata = mem[addr];
  end
endmodule

// File: rtl/bus_merge.sv
module bus_merge #(
  parameter int N = 3,
  parameter int W = 4
) (
  input  logic [N-1:0]   en,
  input  logic [N*W-1:0] data,
  output logic [W-1:0]   y
);
  logic [W-1:0] gated [N];

  for (genvar i = 0; i < N; i++) begin : g_gate
    assign gated[i] = data[i*W +: W] & {W{en[i]}};
  end

  always_comb begin
    y = '0;
    for (int i = 0; i < N; i++) y = y | gated[i];
  end
endmodule

// File: rtl/mem_subsys.sv
module mem_subsys #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_addr_sel,
  input  logic              sw_data_sel,
  input  logic [ADDR_W-1:0] sw_addr,
  input  logic [DATA_W-1:0] sw_data,
  input  logic              ram_ld,
  input  logic              ram_rd,
  input  logic              mar_ld,
  input  logic              mdr_ld,
  input  logic              gr_ld,
  input  logic              gr_oe,
  input  logic              ext_oe,
  input  logic [DATA_W-1:0] ext_data,
  output logic [DATA_W-1:0] bus_out,
  output logic [DATA_W-1:0] mar_q,
  output logic [DATA_W-1:0] mdr_q,
  output logic [DATA_W-1:0] gr_q
);
  import mem_pkg::*;

  localparam int NDRV = N_BUS_DRV;

  logic                 rst_n_sync;
  logic [ADDR_W-1:0]    ram_addr;
  logic [DATA_W-1:0]    ram_din;
  logic [DATA_W-1:0]    ram_dout;
  logic [DATA_W-1:0]    bus;
  logic [NDRV-1:0]      drv_en;
  logic [NDRV*DATA_W-1:0] drv_data;

  rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_sync)
  );

  // Address register is a bus-wide register; low bits form the RAM address
  sel_mux2 #(.W(ADDR_W)) u_addr_mux (
    .sel(sw_addr_sel), .in0(mar_q[ADDR_W-1:0]), .in1(sw_addr), .y(ram_addr)
  );

  sel_mux2 #(.W(DATA_W)) u_data_mux (
    .sel(sw_data_sel), .in0(mdr_q), .in1(sw_data), .y(ram_din)
  );

  ram_core #(.AW(ADDR_W), .DW(DATA_W)) u_ram (
    .clk(clk), .we(ram_ld), .addr(ram_addr), .wdata(ram_din), .rdata(ram_dout)
  );

  load_reg #(.W(DATA_W)) u_mar (
    .clk(clk), .rst_n(rst_n_sync), .ld(mar_ld), .d(bus), .q(mar_q)
  );
  load_reg #(.W(DATA_W)) u_mdr (
    .clk(clk), .rst_n(rst_n_sync), .ld(mdr_ld), .d(bus), .q(mdr_q)
  );
  load_reg #(.W(DATA_W)) u_gr (
    .clk(clk), .rst_n(rst_n_sync), .ld(gr_ld), .d(bus), .q(gr_q)
  );

  always_comb begin
    drv_en = '0;
    drv_en[DRV_RAM] = ram_rd;
    drv_en[DRV_GR]  = gr_oe;
    drv_en[DRV_EXT] = ext_oe;
    drv_data = '0;
    drv_data[DRV_RAM*DATA_W +: DATA_W] = ram_dout;
    drv_data[DRV_GR*DATA_W  +: DATA_W] = gr_q;
    drv_data[DRV_EXT*DATA_W +: DATA_W] = ext_data;
  end

  bus_merge #(.N(NDRV), .W(DATA_W)) u_bus (
    .en(drv_en), .data(drv_data), .y(bus)
  );

  assign bus_out = bus;
endmodule

// File: rtl/mem_subsys_chk.sv
module mem_subsys_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 4
) (
  input logic              clk,
  input logic              rst_ok,
  input logic              sw_addr_sel,
  input logic              sw_data_sel,
  input logic [ADDR_W-1:0] sw_addr,
  input logic [DATA_W-1:0] sw_data,
  input logic [ADDR_W-1:0] ram_addr,
  input logic [DATA_W-1:0] ram_din,
  input logic              ram_rd,
  input logic              mar_ld,
  input logic              mdr_ld,
  input logic              gr_ld,
  input logic              gr_oe,
  input logic              ext_oe,
  input logic [DATA_W-1:0] ext_data,
  input logic [DATA_W-1:0] bus,
  input logic [DATA_W-1:0] mar_q,
  input logic [DATA_W-1:0] mdr_q,
  input logic [DATA_W-1:0] gr_q
);
  assert_addr_sw_R1: assert property (@(posedge clk) disable iff (!rst_ok)
    sw_addr_sel |-> ram_addr == sw_addr);
  assert_addr_mar_R1: assert property (@(posedge clk) disable iff (!rst_ok)
    !sw_addr_sel |-> ram_addr == mar_q[ADDR_W-1:0]);
  assert_data_sw_R2: assert property (@(posedge clk) disable iff (!rst_ok)
    sw_data_sel |-> ram_din == sw_data);
  assert_data_mdr_R2: assert property (@(posedge clk) disable iff (!rst_ok)
    !sw_data_sel |-> ram_din == mdr_q);
  assert_gr_drive_R5: assert property (@(posedge clk) disable iff (!rst_ok)
    (gr_oe && !ram_rd && !ext_oe) |-> bus == gr_q);
  assert_ext_drive_R5: assert property (@(posedge clk) disable iff (!rst_ok)
    (ext_oe && !ram_rd && !gr_oe) |-> bus == ext_data);
  assert_idle_zero_R6: assert property (@(posedge clk) disable iff (!rst_ok)
    !(ram_rd || gr_oe || ext_oe) |-> bus == '0);
  assert_single_driver_R6: assert property (@(posedge clk) disable iff (!rst_ok)
    $countones({ram_rd, gr_oe, ext_oe}) <= 1);
  assert_mar_load_R7: assert property (@(posedge clk) disable iff (!rst_ok)
    mar_ld |=> mar_q == $past(bus));
  assert_mdr_load_R7: assert property (@(posedge clk) disable iff (!rst_ok)
    mdr_ld |=> mdr_q == $past(bus));
  assert_gr_load_R7: assert property (@(posedge clk) disable iff (!rst_ok)
    gr_ld |=> gr_q == $past(bus));
  assert_mar_hold_R8: assert property (@(posedge clk) disable iff (!rst_ok)
    !mar_ld |=> $stable(mar_q));
  assert_mdr_hold_R8: assert property (@(posedge clk) disable iff (!rst_ok)
    !mdr_ld |=> $stable(mdr_q));
  assert_gr_hold_R8: assert property (@(posedge clk) disable iff (!rst_ok)
    !gr_ld |=> $stable(gr_q));
endmodule

bind mem_subsys mem_subsys_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_ok(rst_n_sync),
  .sw_addr_sel(sw_addr_sel), .sw_data_sel(sw_data_sel),
  .sw_addr(sw_addr), .sw_data(sw_data),
  .ram_addr(ram_addr), .ram_din(ram_din), .ram_rd(ram_rd),
  .mar_ld(mar_ld), .mdr_ld(mdr_ld), .gr_ld(gr_ld),
  .gr_oe(gr_oe), .ext_oe(ext_oe), .ext_data(ext_data),
  .bus(bus), .mar_q(mar_q), .mdr_q(mdr_q), .gr_q(gr_q)
);

// File: tb/test_mem_subsys.sv
`timescale 1ns/1ps
module test_mem_subsys;
  localparam int AW = 4;
  localparam int DW = 4;
  localparam int DEPTH = 1 << AW;
  localparam real HALF = 2.5;

  logic clk = 1'b0;
  logic rst_n;
  logic sw_addr_sel, sw_data_sel;
  logic [AW-1:0] sw_addr;
  logic [DW-1:0] sw_data;
  logic ram_ld, ram_rd, mar_ld, mdr_ld, gr_ld, gr_oe, ext_oe;
  logic [DW-1:0] ext_data;
  logic [DW-1:0] bus_out, mar_q, mdr_q, gr_q;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // Bench model
  logic [DW-1:0] m_mem [DEPTH];
  bit            m_valid [DEPTH];
  logic [DW-1:0] m_mar, m_mdr, m_gr;

  always #(HALF) clk = ~clk;

  mem_subsys #(.ADDR_W(AW), .DATA_W(DW)) i_mem_subsys (
    .clk(clk), .rst_n(rst_n),
    .sw_addr_sel(sw_addr_sel), .sw_data_sel(sw_data_sel),
    .sw_addr(sw_addr), .sw_data(sw_data),
    .ram_ld(ram_ld), .ram_rd(ram_rd), .mar_ld(mar_ld), .mdr_ld(mdr_ld),
    .gr_ld(gr_ld), .gr_oe(gr_oe), .ext_oe(ext_oe), .ext_data(ext_data),
    .bus_out(bus_out), .mar_q(mar_q), .mdr_q(mdr_q), .gr_q(gr_q)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [AW-1:0] f_addr();
    return sw_addr_sel ? sw_addr : m_mar[AW-1:0];
  endfunction

  function automatic logic [DW-1:0] f_din();
    return sw_data_sel ? sw_data : m_mdr;
  endfunction

  function automatic logic [DW-1:0] f_bus();
    logic [DW-1:0] b = '0;
    if (ram_rd) b = b | m_mem[f_addr()];
    if (gr_oe)  b = b | m_gr;
    if (ext_oe) b = b | ext_data;
    return b;
  endfunction

  task automatic idle();
    ram_ld = 0; ram_rd = 0; mar_ld = 0; mdr_ld = 0;
    gr_ld = 0; gr_oe = 0; ext_oe = 0;
  endtask

  // Inputs are already applied (at a falling edge). Check bus, clock, check registers.
  task automatic step();
    logic [DW-1:0] eb;
    string tag;
    #1;
    eb = f_bus();
    if (ram_rd) tag = m_valid[f_addr()] ? "R4 ram read" : "";
    else if (gr_oe) tag = "R5 gr drive";
    else if (ext_oe) tag = "R5 ext drive";
    else tag = "R6 idle bus";
    if (tag != "") check(bus_out == eb, tag, bus_out, eb);
    @(posedge clk);
    if (ram_ld) begin
      m_mem[f_addr()] = f_din();
      m_valid[f_addr()] = 1;
    end
    if (mar_ld) m_mar = eb;
    if (mdr_ld) m_mdr = eb;
    if (gr_ld)  m_gr  = eb;
    @(negedge clk);
    check(mar_q == m_mar, mar_ld ? "R7 mar load" : "R8 mar hold", mar_q, m_mar);
    check(mdr_q == m_mdr, mdr_ld ? "R7 mdr load" : "R8 mdr hold", mdr_q, m_mdr);
    check(gr_q  == m_gr,  gr_ld  ? "R7 gr load"  : "R8 gr hold",  gr_q,  m_gr);
  endtask

  task automatic read_sw(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
    idle(); sw_addr_sel = 1; sw_addr = a; ram_rd = 1;
    #1;
    check(bus_out == exp, tag, bus_out, exp);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(HALF * 2 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < DEPTH; i++) m_valid[i] = 0;
    m_mar = '0; m_mdr = '0; m_gr = '0;
    idle();
    sw_addr_sel = 1; sw_data_sel = 1; sw_addr = '0; sw_data = '0; ext_data = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    check(mar_q == 0 && mdr_q == 0 && gr_q == 0, "R9 reset regs", {mar_q, mdr_q, gr_q}, 0);
    check(bus_out == 0, "R6 idle bus in reset", bus_out, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check(mar_q == 0 && mdr_q == 0 && gr_q == 0, "R9 sync release", {mar_q, mdr_q, gr_q}, 0);
    repeat (2) @(negedge clk);

    // Hand programming: 5@0, 9@1, 6@2 (R1, R2, R3)
    idle(); sw_addr_sel = 1; sw_data_sel = 1; sw_addr = 0; sw_data = 5; ram_ld = 1; step();
    sw_addr = 1; sw_data = 9; step();
    sw_addr = 2; sw_data = 6; step();
    read_sw(0, 5, "R3 R1 R2 word0");
    read_sw(1, 9, "R3 word1");
    read_sw(2, 6, "R3 word2");

    // R10: clock edges with ram_ld low and moving switches leave RAM intact
    idle(); sw_addr = 1; sw_data = 3; step();
    sw_addr = 2; sw_data = 15; step();
    read_sw(1, 9, "R10 word1 kept");
    read_sw(2, 6, "R10 word2 kept");

    // R12: RAM word 0 into general register
    idle(); sw_addr_sel = 1; sw_addr = 0; ram_rd = 1; gr_ld = 1; step();
    check(gr_q == 5, "R12 ram to gr", gr_q, 5);

    // R11: general register into RAM word 3 through MDR
    idle(); sw_data_sel = 0; gr_oe = 1; mdr_ld = 1; step();
    check(mdr_q == 5, "R11 mdr from gr", mdr_q, 5);
    idle(); sw_addr_sel = 1; sw_addr = 3; ram_ld = 1; step();
    read_sw(3, 5, "R11 word3");

    // R1/R7: address register path via external agent
    idle(); ext_oe = 1; ext_data = 2; mar_ld = 1; step();
    idle(); sw_addr_sel = 0; sw_addr = 1; ram_rd = 1;
    #1; check(bus_out == 6, "R1 mar selects word2", bus_out, 6);
    @(negedge clk);
    // R2: MDR path with switch address from MAR
    idle(); ext_oe = 1; ext_data = 11; mdr_ld = 1; step();
    idle(); sw_addr_sel = 0; sw_data_sel = 0; sw_data = 1; ram_ld = 1; step();
    read_sw(2, 11, "R2 mdr data stored");

    // Constrained random mix
    for (int n = 0; n < 600; n++) begin
      int drv;
      idle();
      sw_addr_sel = 1'($urandom);
      sw_data_sel = 1'($urandom);
      sw_addr = AW'($urandom);
      sw_data = DW'($urandom);
      ext_data = DW'($urandom);
      drv = $urandom % 4;
      ram_rd = (drv == 1);
      gr_oe  = (drv == 2);
      ext_oe = (drv == 3);
      ram_ld = ($urandom % 3) == 0;
      mar_ld = 1'($urandom);
      mdr_ld = 1'($urandom);
      gr_ld  = 1'($urandom);
      step();
    end

    // R9: RAM survives a reset, registers clear
    idle(); rst_n = 0;
    @(negedge clk);
    m_mar = '0; m_mdr = '0; m_gr = '0;
    check(gr_q == 0, "R9 gr cleared", gr_q, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    for (int a = 0; a < DEPTH; a++)
      if (m_valid[a]) read_sw(AW'(a), m_mem[a], "R9 ram retained");

    idle();
    finish_run();
  end
endmodule